// File: doc/BRIEF.md
# Line Error Counter Bank with Interrupts

This block holds the receive-side line-error performance counters of a T1/E1 framer. Four counters run side by side. An 8-bit counter tracks received alignment words that carry any bit error. Two 10-bit counters track E-bit errors and CRC-4 errors. A 16-bit counter tracks line-code violations that are not part of the legal zero-substitution pattern. Each counter advances on a one-cycle error strobe from the line decoder or the framer. Software reads and presets the counters over a byte-wide bus with a page/address decode.

Each counter has two interrupt sources. The single-event source fires whenever the counter's least significant bit toggles through counting. The overflow source fires when the counter wraps from all-ones to zero. Both sources are sticky and clear when read. Two mask words gate them onto one combined interrupt line.

A wide counter is preset in two steps, and a small write-order state machine per wide counter controls the sequence. It has two states, ST_IDLE and ST_STAGED. In ST_IDLE, a low-byte write stores the byte and moves to ST_STAGED, and a high-byte write is ignored. In ST_STAGED, another low-byte write replaces the stored byte. A high-byte write loads both bytes into the counter in one cycle and returns to ST_IDLE. The 8-bit counter has no state machine and loads directly.

Top module: `line_err_counters`

## Requirements
- R1: After reset every counter, staging register, mask word and status bit is zero, the interrupt line is low and read data is 0x00.
- R2: The violation counter is 16 bits wide and counts one per `err_bpv` strobe. It wraps from 0xFFFF to 0x0000 and is read at counter page 0x4, address 0x05 (bits 7:0) and address 0x06 (bits 15:8).
- R3: The E-bit counter (addresses 0x01 low / 0x02 high) and the CRC-4 counter (addresses 0x03 low / 0x04 high) are 10 bits wide. Bits 1:0 of the high byte hold count bits 9:8, the upper six bits read zero, and each counter wraps from 0x3FF to 0x000.
- R4: The alignment-error counter is 8 bits wide at address 0x00. A write there loads it directly, and it wraps from 0xFF to 0x00.
- R5: For a wide counter, a low-byte write changes nothing visible. The next high-byte write loads {high, low} into the counter in a single cycle, and strobes that arrive between the two writes are still counted.
- R6: A high-byte write with no low byte staged since the last commit leaves the counter unchanged.
- R7: When a counter is loaded in the same cycle as its error strobe, the loaded value is kept, the strobe is dropped and no status bit is set for it.
- R8: Each counted strobe sets that counter's single-event status bit in `stat_single`; the bit order is 0 alignment, 1 E-bit, 2 CRC-4, 3 violation. Status bits stay set until cleared.
- R9: A wrap from all-ones to zero sets the counter's bit in `stat_wrap`, using the same bit order as R8.
- R10: `irq` is high exactly when some status bit is set and its mask bit is set. The single-event mask is written at interrupt page 0x1, address 0x00, and the overflow mask at address 0x01. Both masks use bits 3:0 in the R8 order.
- R11: A read of interrupt page address 0x02 (single-event status) or 0x03 (overflow status) returns the status and then clears it. An event in the same cycle as the read leaves its bit set.
- R12: `bus_rdata` is loaded one cycle after a `bus_rd` and holds until the next read. Mask words read back at their write addresses, and unmapped pages or addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_fas | input | 1 | Errored alignment word strobe |
| err_ebit | input | 1 | E-bit error strobe |
| err_crc | input | 1 | CRC-4 error strobe |
| err_bpv | input | 1 | Line-code violation strobe |
| bus_page | input | 4 | Register page select |
| bus_addr | input | 5 | Register address within page |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| stat_single | output | 4 | Sticky single-event status |
| stat_wrap | output | 4 | Sticky overflow status |
| irq | output | 1 | Combined masked interrupt |

## Verification
The hardest situation to reach is a wrap of the 16-bit counter, which would take 65,536 strobes from reset. The stimulus instead presets 0xFFFE through the staged low/high write sequence and then sends two strobes. A second hard case is a commit that collides with a strobe on the same cycle. The bench drives the strobe on exactly the cycle of the high-byte write, after first clearing the status so that a wrongly counted event would appear.

// File: rtl/lec_pkg.sv
package lec_pkg;
    parameter int DW       = 8;
    parameter int NUM_CNT  = 4;
    parameter int CNT_MAXW = 16;
    // index order: 0 alignment, 1 E-bit, 2 CRC-4, 3 violation
    parameter int CNT_W [NUM_CNT] = '{8, 10, 10, 16};
    parameter logic [4:0] A_MSK_SINGLE = 5'h00;
    parameter logic [4:0] A_MSK_WRAP   = 5'h01;
    parameter logic [4:0] A_ST_SINGLE  = 5'h02;
    parameter logic [4:0] A_ST_WRAP    = 5'h03;
endpackage

// File: rtl/lec_counter.sv
module lec_counter #(
    parameter int W     = 16,
    parameter int OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_stb,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [7:0]       wr_data,
    output logic [OUT_W-1:0] count,
    output logic             ev_single,
    output logic             ev_wrap
);
    localparam logic [W-1:0] CMAX = '1;

    logic [W-1:0] cnt_q;
    logic [W-1:0] load_val;
    logic         load;
    logic         do_inc;

    generate
        if (W > 8) begin : g_wide
            typedef enum logic {ST_IDLE, ST_STAGED} stage_e;
            stage_e     st_q, st_d;
            logic [7:0] stage_q, stage_d;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    st_q    <= ST_IDLE;
                    stage_q <= '0;
                end else begin
                    st_q    <= st_d;
                    stage_q <= stage_d;
                end
            end

            always_comb begin
                st_d    = st_q;
                stage_d = stage_q;
                load    = 1'b0;
                unique case (st_q)
                    ST_IDLE: begin
                        if (wr_lo) begin
                            stage_d = wr_data;
                            st_d    = ST_STAGED;
                        end
                    end
                    ST_STAGED: begin
                        if (wr_lo) begin
                            stage_d = wr_data;
                        end else if (wr_hi) begin
                            load = 1'b1;
                            st_d = ST_IDLE;
                        end
                    end
                    default: st_d = ST_IDLE;
                endcase
            end

            assign load_val = W'({wr_data, stage_q});

            AST_HI_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q == ST_IDLE && wr_hi && !err_stb) |=> $stable(cnt_q)); // R6
            AST_STAGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q == ST_STAGED && !wr_hi && !err_stb) |=> $stable(cnt_q)); // R5
        end else begin : g_narrow
            assign load     = wr_lo | wr_hi;
            assign load_val = W'(wr_data);
        end
    endgenerate

    assign do_inc    = err_stb & ~load;
    assign ev_single = do_inc;
    assign ev_wrap   = do_inc & (cnt_q == CMAX);
    assign count     = OUT_W'(cnt_q);

    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (load)   cnt_q <= load_val;
        else if (do_inc) cnt_q <= cnt_q + 1'b1;
    end

    AST_EVENT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_single |=> (cnt_q == $past(cnt_q) + 1'b1)); // R8
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ev_wrap |=> (cnt_q == '0)); // R9
    AST_COMMIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (load && err_stb) |=> (cnt_q == $past(load_val))); // R7
endmodule

// File: rtl/lec_irq.sv
module lec_irq #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev_single,
    input  logic [N-1:0] ev_wrap,
    input  logic         msk_wr_single,
    input  logic         msk_wr_wrap,
    input  logic [N-1:0] msk_data,
    input  logic         clr_single,
    input  logic         clr_wrap,
    output logic [N-1:0] msk_single,
    output logic [N-1:0] msk_wrap,
    output logic [N-1:0] st_single,
    output logic [N-1:0] st_wrap,
    output logic         irq
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msk_single <= '0;
            msk_wrap   <= '0;
            st_single  <= '0;
            st_wrap    <= '0;
        end else begin
            if (msk_wr_single) msk_single <= msk_data;
            if (msk_wr_wrap)   msk_wrap   <= msk_data;
            st_single <= (clr_single ? '0 : st_single) | ev_single;
            st_wrap   <= (clr_wrap   ? '0 : st_wrap)   | ev_wrap;
        end
    end

    assign irq = (|(st_single & msk_single)) | (|(st_wrap & msk_wrap));

    AST_SINGLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_single |=> ((st_single & $past(st_single)) == $past(st_single))); // R8
    AST_WRAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wrap |=> ((st_wrap & $past(st_wrap)) == $past(st_wrap))); // R9
    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_single && ev_single == '0) |=> (st_single == '0)); // R11
endmodule

// File: rtl/line_err_counters.sv
module line_err_counters #(
    parameter logic [3:0] PAGE_CNT = 4'h4,
    parameter logic [3:0] PAGE_IRQ = 4'h1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       err_fas,
    input  logic       err_ebit,
    input  logic       err_crc,
    input  logic       err_bpv,
    input  logic [3:0] bus_page,
    input  logic [4:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic [3:0] stat_single,
    output logic [3:0] stat_wrap,
    output logic       irq
);
    import lec_pkg::*;

    logic [NUM_CNT-1:0]  err_vec, ev_single, ev_wrap;
    logic [CNT_MAXW-1:0] cnt_bus [NUM_CNT];
    logic [NUM_CNT-1:0]  msk_single, msk_wrap;
    logic                pg_cnt, pg_irq;
    logic                msk_wr_single, msk_wr_wrap, clr_single, clr_wrap;
    logic [DW-1:0]       rd_mux;

    assign err_vec = {err_bpv, err_crc, err_ebit, err_fas};
    assign pg_cnt  = (bus_page == PAGE_CNT);
    assign pg_irq  = (bus_page == PAGE_IRQ);

    generate
        for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
            localparam int LO_A = (k == 0) ? 0 : 2 * k - 1;
            localparam int HI_A = 2 * k;
            logic wr_lo, wr_hi;
            assign wr_lo = bus_wr & pg_cnt & (bus_addr == 5'(LO_A));
            assign wr_hi = (k > 0) & bus_wr & pg_cnt & (bus_addr == 5'(HI_A));
            lec_counter #(.W(CNT_W[k]), .OUT_W(CNT_MAXW)) u_cnt (
                .clk      (clk),
                .rst_n    (rst_n),
                .err_stb  (err_vec[k]),
                .wr_lo    (wr_lo),
                .wr_hi    (wr_hi),
                .wr_data  (bus_wdata),
                .count    (cnt_bus[k]),
                .ev_single(ev_single[k]),
                .ev_wrap  (ev_wrap[k])
            );
        end
    endgenerate

    assign msk_wr_single = bus_wr & pg_irq & (bus_addr == A_MSK_SINGLE);
    assign msk_wr_wrap   = bus_wr & pg_irq & (bus_addr == A_MSK_WRAP);
    assign clr_single    = bus_rd & pg_irq & (bus_addr == A_ST_SINGLE);
    assign clr_wrap      = bus_rd & pg_irq & (bus_addr == A_ST_WRAP);

    lec_irq #(.N(NUM_CNT)) u_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev_single    (ev_single),
        .ev_wrap      (ev_wrap),
        .msk_wr_single(msk_wr_single),
        .msk_wr_wrap  (msk_wr_wrap),
        .msk_data     (bus_wdata[NUM_CNT-1:0]),
        .clr_single   (clr_single),
        .clr_wrap     (clr_wrap),
        .msk_single   (msk_single),
        .msk_wrap     (msk_wrap),
        .st_single    (stat_single),
        .st_wrap      (stat_wrap),
        .irq          (irq)
    );

    always_comb begin
        rd_mux = '0;
        if (pg_cnt) begin
            for (int k = 0; k < NUM_CNT; k++) begin
                if (bus_addr == 5'((k == 0) ? 0 : 2 * k - 1)) rd_mux = cnt_bus[k][7:0];
                if (k > 0 && bus_addr == 5'(2 * k))            rd_mux = cnt_bus[k][15:8];
            end
        end else if (pg_irq) begin
            unique case (bus_addr)
                A_MSK_SINGLE: rd_mux = DW'(msk_single);
                A_MSK_WRAP:   rd_mux = DW'(msk_wrap);
                A_ST_SINGLE:  rd_mux = DW'(stat_single);
                A_ST_WRAP:    rd_mux = DW'(stat_wrap);
                default:      rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R12
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past((|ev_single) || (|ev_wrap) || msk_wr_single || msk_wr_wrap)); // R10
endmodule

// File: tb/sim_line_err_counters.sv
module sim_line_err_counters;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       err_fas = 0, err_ebit = 0, err_crc = 0, err_bpv = 0;
    logic [3:0] bus_page = '0;
    logic [4:0] bus_addr = '0;
    logic       bus_wr = 0, bus_rd = 0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [3:0] stat_single, stat_wrap;
    logic       irq;

    int n_tests = 0;
    int n_fail  = 0;

    // behavioural reference state
    int m_cnt[4], m_stage[4], m_staged[4];
    int m_max[4] = '{255, 1023, 1023, 65535};
    int m_ss, m_sw, m_ms, m_mw, m_rdata;

    line_err_counters u0 (
        .clk(clk), .rst_n(rst_n),
        .err_fas(err_fas), .err_ebit(err_ebit), .err_crc(err_crc), .err_bpv(err_bpv),
        .bus_page(bus_page), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .stat_single(stat_single), .stat_wrap(stat_wrap), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int model_read(input int pg, input int ad);
        if (pg == 4) begin
            if (ad == 0) return m_cnt[0] & 255;
            if (ad >= 1 && ad <= 6) begin
                if (ad % 2 == 1) return m_cnt[(ad + 1) / 2] & 255;
                return m_cnt[ad / 2] >> 8;
            end
            return 0;
        end
        if (pg == 1) begin
            case (ad)
                0: return m_ms;
                1: return m_mw;
                2: return m_ss;
                3: return m_sw;
                default: return 0;
            endcase
        end
        return 0;
    endfunction

    task automatic step(input logic [3:0] e, input logic w, input logic r,
                        input logic [3:0] pg, input logic [4:0] ad, input logic [7:0] wd);
        int evs = 0;
        int evw = 0;
        {err_bpv, err_crc, err_ebit, err_fas} = e;
        bus_wr = w; bus_rd = r; bus_page = pg; bus_addr = ad; bus_wdata = wd;
        if (r) m_rdata = model_read(pg, ad);
        for (int k = 0; k < 4; k++) begin
            bit ld = 0;
            int lv = 0;
            if (w && pg == 4) begin
                if (k == 0 && ad == 0) begin ld = 1; lv = wd; end
                else if (k > 0 && ad == 2 * k - 1) begin m_stage[k] = wd; m_staged[k] = 1; end
                else if (k > 0 && ad == 2 * k && m_staged[k] != 0) begin
                    ld = 1; lv = ((wd << 8) | m_stage[k]) & m_max[k]; m_staged[k] = 0;
                end
            end
            if (ld) m_cnt[k] = lv;
            else if (e[k]) begin
                evs |= (1 << k);
                if (m_cnt[k] == m_max[k]) evw |= (1 << k);
                m_cnt[k] = (m_cnt[k] + 1) & m_max[k];
            end
        end
        if (r && pg == 1 && ad == 2) m_ss = 0;
        if (r && pg == 1 && ad == 3) m_sw = 0;
        m_ss |= evs;
        m_sw |= evw;
        if (w && pg == 1 && ad == 0) m_ms = wd & 15;
        if (w && pg == 1 && ad == 1) m_mw = wd & 15;
        @(posedge clk);
        #1;
        chk(bus_rdata == m_rdata, "R12 rdata", bus_rdata, m_rdata);
        chk(stat_single == m_ss, "R8 single status", stat_single, m_ss);
        chk(stat_wrap == m_sw, "R9 wrap status", stat_wrap, m_sw);
        chk(irq == (((m_ss & m_ms) | (m_sw & m_mw)) != 0), "R10 irq", irq,
            ((m_ss & m_ms) | (m_sw & m_mw)) != 0);
        {err_bpv, err_crc, err_ebit, err_fas} = '0;
        bus_wr = 0; bus_rd = 0;
    endtask

    task automatic rd_chk(input logic [3:0] pg, input logic [4:0] ad, input int exp, input string tag);
        step(4'b0, 1'b0, 1'b1, pg, ad, 8'h00);
        chk(bus_rdata == exp, tag, bus_rdata, exp);
    endtask

    task automatic wr(input logic [3:0] pg, input logic [4:0] ad, input logic [7:0] wd);
        step(4'b0, 1'b1, 1'b0, pg, ad, wd);
    endtask

    initial begin
        #(200000 * 10);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < 4; k++) begin m_cnt[k] = 0; m_stage[k] = 0; m_staged[k] = 0; end
        m_ss = 0; m_sw = 0; m_ms = 0; m_mw = 0; m_rdata = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk(stat_single == 0 && stat_wrap == 0, "R1 status", {stat_single, stat_wrap}, 0);
        chk(irq == 0, "R1 irq", irq, 0);
        chk(bus_rdata == 0, "R1 rdata", bus_rdata, 0);
        for (int a = 0; a < 7; a++) rd_chk(4'h4, 5'(a), 0, "R1 counter zero");
        rd_chk(4'h1, 5'h0, 0, "R1 mask zero");

        // R2 violation counting
        repeat (3) step(4'b1000, 0, 0, 4'h4, 0, 0);
        rd_chk(4'h4, 5'h05, 8'h03, "R2 count three");
        chk(stat_single[3] == 1'b1, "R8 bpv single set", stat_single[3], 1);
        // R5 staged preset
        wr(4'h4, 5'h05, 8'hFE);
        rd_chk(4'h4, 5'h05, 8'h03, "R5 low write staged only");
        wr(4'h4, 5'h06, 8'hFF);
        rd_chk(4'h4, 5'h05, 8'hFE, "R5 commit low");
        rd_chk(4'h4, 5'h06, 8'hFF, "R5 commit high");
        repeat (2) step(4'b1000, 0, 0, 4'h4, 0, 0);
        rd_chk(4'h4, 5'h05, 8'h00, "R2 wrap low");
        rd_chk(4'h4, 5'h06, 8'h00, "R2 wrap high");
        chk(stat_wrap[3] == 1'b1, "R9 bpv wrap", stat_wrap[3], 1);
        // R6 high write without staged low
        wr(4'h4, 5'h06, 8'h12);
        rd_chk(4'h4, 5'h06, 8'h00, "R6 unstaged high ignored");

        // R3 ten-bit counters
        wr(4'h4, 5'h01, 8'hFF);
        wr(4'h4, 5'h02, 8'h07);
        rd_chk(4'h4, 5'h02, 8'h03, "R3 ebit high bits");
        rd_chk(4'h4, 5'h01, 8'hFF, "R3 ebit low");
        step(4'b0010, 0, 0, 4'h4, 0, 0);
        rd_chk(4'h4, 5'h02, 8'h00, "R3 ebit wrap");
        chk(stat_wrap[1] == 1'b1, "R9 ebit wrap", stat_wrap[1], 1);
        repeat (5) step(4'b0100, 0, 0, 4'h4, 0, 0);
        rd_chk(4'h4, 5'h03, 8'h05, "R3 crc count");
        rd_chk(4'h4, 5'h04, 8'h00, "R3 crc high");

        // R4 alignment counter
        wr(4'h4, 5'h00, 8'hFF);
        step(4'b0001, 0, 0, 4'h4, 0, 0);
        rd_chk(4'h4, 5'h00, 8'h00, "R4 fas wrap");
        chk(stat_wrap[0] == 1'b1, "R4 fas wrap status", stat_wrap[0], 1);

        // R7 write beats strobe
        rd_chk(4'h1, 5'h02, m_ss, "R11 single read");
        wr(4'h4, 5'h03, 8'h10);
        step(4'b0100, 1, 0, 4'h4, 5'h04, 8'h00);
        rd_chk(4'h4, 5'h03, 8'h10, "R7 crc commit wins");
        chk(stat_single[2] == 1'b0, "R7 crc no status", stat_single[2], 0);
        step(4'b0001, 1, 0, 4'h4, 5'h00, 8'h20);
        rd_chk(4'h4, 5'h00, 8'h20, "R7 fas write wins");
        chk(stat_single[0] == 1'b0, "R7 fas no status", stat_single[0], 0);

        // R10 masking, R11 clear on read
        rd_chk(4'h1, 5'h02, m_ss, "R11 clear single");
        rd_chk(4'h1, 5'h03, m_sw, "R11 clear wrap");
        chk(irq == 1'b0, "R10 irq low", irq, 0);
        wr(4'h1, 5'h00, 8'h08);
        step(4'b0100, 0, 0, 4'h4, 0, 0);
        chk(irq == 1'b0, "R10 masked crc", irq, 0);
        step(4'b1000, 0, 0, 4'h4, 0, 0);
        chk(irq == 1'b1, "R10 enabled bpv", irq, 1);
        rd_chk(4'h1, 5'h00, 8'h08, "R12 mask readback");
        rd_chk(4'h1, 5'h02, 8'h0C, "R11 status value");
        chk(stat_single == 4'h0, "R11 cleared", stat_single, 0);
        chk(irq == 1'b0, "R10 irq after clear", irq, 0);
        wr(4'h1, 5'h01, 8'h01);
        wr(4'h4, 5'h00, 8'hFF);
        step(4'b0001, 0, 0, 4'h4, 0, 0);
        chk(irq == 1'b1, "R10 overflow irq", irq, 1);
        step(4'b0001, 0, 1, 4'h1, 5'h02, 8'h00);
        chk(stat_single[0] == 1'b1, "R11 event beats clear", stat_single[0], 1);

        // R12 unmapped and hold
        rd_chk(4'h4, 5'h07, 0, "R12 unmapped addr");
        rd_chk(4'h2, 5'h00, 0, "R12 unmapped page");
        rd_chk(4'h1, 5'h00, 8'h08, "R12 mask again");
        step(4'b0, 0, 0, 4'h4, 0, 0);
        chk(bus_rdata == 8'h08, "R12 rdata holds", bus_rdata, 8'h08);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule